// File: doc/BRIEF.md
# Serial Write Receiver for a Display Controller

This block accepts host writes over a slow serial link and turns each received byte into a one-cycle strobe in the core clock domain. Every byte is tagged either as a command (for the command decoder) or as display data (for the display memory write path). The link has a chip select, a serial clock and a serial data line. In one framing, a separate control/data pin tags each byte. In the other framing, that tag is carried in the bit stream as a leading bit.

The framing is chosen by a two-bit mode input that is captured only while reset is held. All link pins are brought into the core clock domain through synchronizer stages. Serial clock edges are found by oversampling with the core clock. The link only writes: there is no read path. Decoding of the command byte and the display memory address are handled by other blocks.

Top module: `ser_wr_rx`

## Requirements
- R1: While reset is high and on the first cycles after it, `cmd_vld` and `dat_vld` are 0 and `rx_byte` is 0x00.
- R2: `mode_sel` is captured only while `rst` is high. Bit 0 equal to 1 selects the in-band framing of 9 bits: one tag bit, then 8 data bits. Bit 0 equal to 0 selects the pin-tagged framing of 8 bits. Changes on `mode_sel` after reset have no effect.
- R3: While `cs_n` is low, one data bit is taken from `sda` on each rising `sck` edge. The data bits are placed MSB first, so the first data bit of a frame becomes `rx_byte[7]`.
- R4: In pin-tagged framing, the tag is the level of `cd_pin` while `sck` is low during the eighth bit (D0). Levels of `cd_pin` at any other time do not change the tag.
- R5: In in-band framing, the first bit of each frame is the tag. `cd_pin` is ignored.
- R6: A tag of 0 pulses `cmd_vld` for exactly one cycle. A tag of 1 pulses `dat_vld` for exactly one cycle. The two strobes are never high together. `rx_byte` carries the byte in the strobe cycle.
- R7: If the final rising `sck` edge of a frame is driven between core clock edges c and c+1, the strobe is high after core edge c+3. This assumes the default of two synchronizer stages.
- R8: `cs_n` high clears any partial frame and produces no strobe. The next bit received with `cs_n` low starts a new frame.
- R9: Frames may follow each other back to back with `cs_n` held low. After each frame, the bit count restarts at zero.
- R10: `rx_byte` changes only in a strobe cycle. It holds the last received byte in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; mode capture window |
| mode_sel | input | 2 | Framing select, bit 0 used (1 = in-band tag, 0 = tag pin) |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sck | input | 1 | Serial clock, asynchronous to clk |
| sda | input | 1 | Serial data |
| cd_pin | input | 1 | Control/data tag pin for pin-tagged framing |
| rx_byte | output | 8 | Last received byte |
| cmd_vld | output | 1 | One-cycle strobe: byte is a command |
| dat_vld | output | 1 | One-cycle strobe: byte is display data |

## Verification
A bit counter that has slipped shows up at the ports immediately: the next strobe arrives one serial bit early or late, and its byte is rotated. An error in the tag path shows up as the wrong strobe going high, in the same cycle a correct strobe would have appeared. A stale partial frame left behind by a chip-select release corrupts the first byte after the next select. Because a bench model is compared against the outputs on every core cycle, each of these faults is caught within three core cycles of the serial edge that exposes it.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

  typedef enum logic {
    FRM_TAGPIN = 1'b0,
    FRM_INBAND = 1'b1
  } frame_mode_e;

  // order of the synchronised pin vector
  localparam int PIN_SCK = 0;
  localparam int PIN_SDA = 1;
  localparam int PIN_CDP = 2;
  localparam int PIN_CSN = 3;
  localparam int PIN_W   = 4;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/ser_edge.sv
module ser_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_mode_e       mode,
  input  logic              cs_act,
  input  logic              rise,
  input  logic              sck_lvl,
  input  logic              sda,
  input  logic              cdp,
  output logic [DATA_W-1:0] byte_o,
  output logic              cmd_o,
  output logic              dat_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_PIN = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_INB = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              tag;
  logic [CNT_W-1:0]  last_idx;
  logic [DATA_W-1:0] next_byte;

  assign last_idx  = (mode == FRM_INBAND) ? LAST_INB : LAST_PIN;
  assign next_byte = {shreg[DATA_W-2:0], sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      shreg  <= '0;
      tag    <= 1'b0;
      byte_o <= '0;
      cmd_o  <= 1'b0;
      dat_o  <= 1'b0;
    end else begin
      cmd_o <= 1'b0;
      dat_o <= 1'b0;
      if (!cs_act) begin
        cnt <= '0;
      end else if (rise) begin
        if (mode == FRM_INBAND && cnt == '0) begin
          tag <= sda;
          cnt <= cnt + 1'b1;
        end else begin
          shreg <= next_byte;
          if (cnt == last_idx) begin
            cnt    <= '0;
            byte_o <= next_byte;
            if (tag) dat_o <= 1'b1;
            else     cmd_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (mode == FRM_TAGPIN && !sck_lvl && cnt == LAST_PIN) begin
        tag <= cdp;
      end
    end
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_o && dat_o));

  // R6
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o |=> !cmd_o);

  // R6
  dat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dat_o |=> !dat_o);

  // R8
  cs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_idx);

  // R7
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o || dat_o) |-> $past(rise && cs_act));

  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(byte_o) |-> (cmd_o || dat_o));

endmodule

// File: rtl/ser_wr_rx.sv
module ser_wr_rx
  import ser_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sda,
  input  logic              cd_pin,
  output logic [DATA_W-1:0] rx_byte,
  output logic              cmd_vld,
  output logic              dat_vld
);

  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_CSN;

  frame_mode_e       mode_q;
  logic [PIN_W-1:0]  pins_raw;
  logic [PIN_W-1:0]  pins_s;
  logic              sck_rise;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= frame_mode_e'(mode_sel[0]);
  end

  always_comb begin
    pins_raw          = '0;
    pins_raw[PIN_SCK] = sck;
    pins_raw[PIN_SDA] = sda;
    pins_raw[PIN_CDP] = cd_pin;
    pins_raw[PIN_CSN] = cs_n;
  end

  ser_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_raw),
    .dout (pins_s)
  );

  ser_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pins_s[PIN_SCK]),
    .rise (sck_rise)
  );

  ser_frame #(
    .DATA_W (DATA_W)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .cs_act  (~pins_s[PIN_CSN]),
    .rise    (sck_rise),
    .sck_lvl (pins_s[PIN_SCK]),
    .sda     (pins_s[PIN_SDA]),
    .cdp     (pins_s[PIN_CDP]),
    .byte_o  (rx_byte),
    .cmd_o   (cmd_vld),
    .dat_o   (dat_vld)
  );

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

endmodule

// File: tb/test_ser_wr_rx.sv
`timescale 1ns/1ps
module test_ser_wr_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sda = 1'b0;
  logic       cd_pin = 1'b0;
  logic [7:0] rx_byte;
  logic       cmd_vld;
  logic       dat_vld;

  always #2.5 clk = ~clk;

  ser_wr_rx i_ser_wr_rx (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n), .sck(sck),
    .sda(sda), .cd_pin(cd_pin), .rx_byte(rx_byte), .cmd_vld(cmd_vld),
    .dat_vld(dat_vld)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  logic [3:0] h1, h2;   // {csn, cd, sda, sck} as seen one and two samples back
  logic       h3_sck;
  int         m_cnt;
  int         m_inband;
  logic [7:0] m_sh;
  logic       m_tag;
  logic       exp_cmd, exp_dat;
  logic [7:0] exp_byte;

  // observation state
  int         n_cmd = 0, n_dat = 0;
  logic [7:0] last_byte = 8'h00;
  int         last_kind = 0;
  int         stb_cyc = 0;
  int         rise_cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_inband = mode_sel[0];
      h1 = 4'b1000; h2 = 4'b1000; h3_sck = 1'b0;
      m_cnt = 0; m_sh = 8'h00; m_tag = 1'b0;
      exp_cmd = 0; exp_dat = 0; exp_byte = 8'h00;
    end else begin
      exp_cmd = 0; exp_dat = 0;
      if (h2[3]) begin
        m_cnt = 0;
      end else if (h2[0] && !h3_sck) begin
        if (m_inband != 0 && m_cnt == 0) begin
          m_tag = h2[1];
          m_cnt = 1;
        end else begin
          m_sh = {m_sh[6:0], h2[1]};
          m_cnt++;
          if (m_cnt == (m_inband != 0 ? 9 : 8)) begin
            m_cnt = 0;
            exp_byte = m_sh;
            if (m_tag) exp_dat = 1; else exp_cmd = 1;
          end
        end
      end else if (m_inband == 0 && !h2[0] && m_cnt == 7) begin
        m_tag = h2[2];
      end
      h3_sck = h2[0];
      h2 = h1;
      h1 = {cs_n, cd_pin, sda, sck};
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cmd_vld == exp_cmd && dat_vld == exp_dat, "R6 R7 strobe",
            {cmd_vld, dat_vld}, {exp_cmd, exp_dat});
      check(rx_byte == exp_byte, "R3 R10 byte", rx_byte, exp_byte);
    end
    if (cmd_vld || dat_vld) begin
      last_byte = rx_byte;
      last_kind = cmd_vld ? 1 : 2;
      stb_cyc   = cyc;
      if (cmd_vld) n_cmd++;
      if (dat_vld) n_dat++;
    end
  end

  task automatic bit_out(input logic b, input logic cd_low, input logic cd_high);
    sck = 1'b0; sda = b; cd_pin = cd_low;
    repeat (3) @(negedge clk);
    sck = 1'b1; cd_pin = cd_high; rise_cyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  // pin-tagged frame; cd pin opposite to the tag except in the D0 low phase
  task automatic frame4(input logic [7:0] v, input logic t);
    for (int i = 7; i >= 0; i--)
      bit_out(v[i], (i == 0) ? t : ~t, ~t);
  endtask

  // in-band frame; cd pin toggles as junk
  task automatic frame3(input logic [7:0] v, input logic t);
    bit_out(t, ~t, t);
    for (int i = 7; i >= 0; i--)
      bit_out(v[i], v[i], ~v[i]);
  endtask

  task automatic sel_on;
    @(negedge clk); cs_n = 1'b0; sck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off;
    sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; cs_n = 1'b1; sck = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic flush;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int c0, d0;
    do_reset(2'b00);
    @(negedge clk);
    // R1
    check(!cmd_vld && !dat_vld, "R1 strobes after reset", {cmd_vld, dat_vld}, 0);
    check(rx_byte == 8'h00, "R1 byte after reset", rx_byte, 0);

    // pin-tagged framing, back to back
    sel_on();
    frame4(8'hA5, 1'b0);
    flush();
    check(last_kind == 1 && last_byte == 8'hA5, "R4 command tag from pin", last_byte, 8'hA5);
    check(stb_cyc - rise_cyc == 3, "R7 strobe latency", stb_cyc - rise_cyc, 3);
    frame4(8'h3C, 1'b1);
    flush();
    check(last_kind == 2 && last_byte == 8'h3C, "R9 back to back data", last_byte, 8'h3C);
    sel_off();

    // partial frame aborted by chip select
    c0 = n_cmd; d0 = n_dat;
    sel_on();
    for (int i = 0; i < 5; i++) bit_out(1'b1, 1'b0, 1'b0);
    sel_off();
    check(n_cmd == c0 && n_dat == d0, "R8 no strobe from partial", n_cmd + n_dat, c0 + d0);
    sel_on();
    frame4(8'h96, 1'b1);
    flush();
    check(last_kind == 2 && last_byte == 8'h96, "R8 frame after abort", last_byte, 8'h96);
    sel_off();
    repeat (20) @(negedge clk);
    check(rx_byte == 8'h96, "R10 byte held", rx_byte, 8'h96);

    // in-band framing; mode pin changed after reset
    do_reset(2'b01);
    @(negedge clk);
    mode_sel = 2'b00;
    sel_on();
    frame3(8'h5A, 1'b1);
    flush();
    check(last_kind == 2 && last_byte == 8'h5A, "R2 mode held after reset", last_byte, 8'h5A);
    frame3(8'hC3, 1'b0);
    flush();
    check(last_kind == 1 && last_byte == 8'hC3, "R5 in-band command tag", last_byte, 8'hC3);
    check(stb_cyc - rise_cyc == 3, "R7 strobe latency in-band", stb_cyc - rise_cyc, 3);
    sel_off();
    c0 = n_cmd; d0 = n_dat;
    sel_on();
    for (int i = 0; i < 4; i++) bit_out(1'b1, 1'b1, 1'b1);
    sel_off();
    check(n_cmd == c0 && n_dat == d0, "R8 no strobe from in-band partial", n_cmd + n_dat, c0 + d0);
    sel_on();
    frame3(8'h81, 1'b0);
    frame3(8'h7E, 1'b1);
    flush();
    check(n_cmd == c0 + 1 && n_dat == d0 + 1, "R9 in-band back to back", n_cmd + n_dat, c0 + d0 + 2);
    check(last_byte == 8'h7E, "R3 msb first in-band", last_byte, 8'h7E);
    sel_off();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule